// File: doc/BRIEF.md
# Cascaded Longest-Prefix Match Stage

This block is one link in a chain of identical stages that together resolve the longest matching prefix for a batch of eight IPv4 destination addresses. The routing table is divided among the stages. Each stage holds no table of its own. Its slice of the table arrives as a stream of entries, and each entry carries a network address, a mask and a next hop.

A batch starts with eight load beats, in lane order. Each beat carries one destination address together with the best-match state handed on by the previous stage: the best mask length, the next hop and a flag that records whether any match has been seen. The first stage in a chain loads length 0, hop 0 and a clear flag. The stage then accepts one routing entry per cycle and offers it to all eight lanes at once. Each lane updates its own best-match state. The last entry is marked by a flag. After it, the stage presents the eight updated results as eight output beats in lane order. Those results become the load data for the next stage. Only the final stage of the chain holds the true next hops.

Top module: `lpm_stage`

## Requirements
- R1: After reset, `ld_ready` is 1, `ent_ready` is 0 and `res_valid` is 0.
- R2: The stage accepts exactly eight load beats, one per `ld_valid && ld_ready` cycle, into lanes 0 to 7 in that order. After the eighth beat, `ld_ready` is 0 and `ent_ready` is 1.
- R3: An entry matches a lane when `(lane address AND ent_mask) XOR ent_net` is all zeros.
- R4: The mask length of an entry is the number of single-bit left shifts of `ent_mask` needed to make it zero. This equals 32 minus the index of the lowest set bit, or 0 for a zero mask, so an all-ones mask gives 32 and a mask of 0x00010000 gives 16.
- R5: On a match whose lane flag is already set, the lane takes the entry's next hop and length only when the length is strictly greater than its current best.
- R6: On a match whose lane flag is clear, the lane also takes an entry whose length equals its current best. Any match sets the flag, so a zero-length default route can win in the first stage.
- R7: An entry that does not match a lane leaves that lane's length, hop and flag unchanged. Loaded state with no match in this stage comes out exactly as it went in.
- R8: While entries are being taken, `ent_ready` stays 1 on every cycle until the entry flagged `ent_last` is accepted, so one entry can be taken per cycle with no bubbles.
- R9: From the cycle after the last entry is accepted, `res_valid` is 1 and eight result beats (`res_len`, `res_hop`, `res_hit`) come out in lane order. A beat that is not accepted keeps `res_valid` and its values stable.
- R10: While entries or results are pending, `ld_ready` is 0. After the eighth result beat is accepted, the stage returns to `ld_ready` = 1 with `res_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat accepted when high |
| ld_addr | input | 32 | Destination address for the current lane |
| ld_len | input | 6 | Inherited best mask length |
| ld_hop | input | 16 | Inherited next hop |
| ld_hit | input | 1 | Inherited flag: a match was already seen |
| ent_valid | input | 1 | Routing entry offered |
| ent_ready | output | 1 | Entry accepted when high |
| ent_net | input | 32 | Entry network address |
| ent_mask | input | 32 | Entry mask |
| ent_hop | input | 16 | Entry next hop |
| ent_last | input | 1 | Marks the final entry of this stage |
| res_valid | output | 1 | Result beat offered |
| res_ready | input | 1 | Result beat taken when high |
| res_len | output | 6 | Best mask length of the current lane |
| res_hop | output | 16 | Best next hop of the current lane |
| res_hit | output | 1 | Match flag of the current lane |

## Verification
The assertions check a set of rules on every cycle. The mask length must agree with an independent shift-until-zero count. Results must appear in the cycle after the last entry and must hold steady under backpressure. The entry port must stay ready without a gap, and loading must be closed while results are pending. What each lane chooses can only be shown by the bench scenarios, which compare the result beats with a model built from the requirements. These choices cover the match test, strictly-longer replacement, the equal-length default-route case in the first stage, and pass-through of inherited state in a later stage.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   localparam int DEF_LANES  = 8;
   localparam int DEF_ADDR_W = 32;
   localparam int DEF_HOP_W  = 16;

   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_RUN  = 2'd1,
      ST_OUT  = 2'd2
   } stage_st_t;
endpackage

// File: rtl/lpm_mask_len.sv
module lpm_mask_len #(
   parameter int ADDR_W = lpm_pkg::DEF_ADDR_W,
   parameter int LEN_W  = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] mask,
   output logic [LEN_W-1:0]  len
);
   // Length is the distance from the lowest set bit to the top of the word.
   always_comb begin
      len = '0;
      for (int i = ADDR_W - 1; i >= 0; i--) begin
         if (mask[i]) len = LEN_W'(ADDR_W - i);
      end
   end
endmodule

// File: rtl/lpm_lane.sv
module lpm_lane #(
   parameter int ADDR_W = lpm_pkg::DEF_ADDR_W,
   parameter int HOP_W  = lpm_pkg::DEF_HOP_W,
   parameter int LEN_W  = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [LEN_W-1:0]  load_len,
   input  logic [HOP_W-1:0]  load_hop,
   input  logic              load_hit,
   input  logic              ent_en,
   input  logic [ADDR_W-1:0] ent_net,
   input  logic [ADDR_W-1:0] ent_mask,
   input  logic [LEN_W-1:0]  ent_len,
   input  logic [HOP_W-1:0]  ent_hop,
   output logic [LEN_W-1:0]  best_len,
   output logic [HOP_W-1:0]  best_hop,
   output logic              best_hit
);
   logic [ADDR_W-1:0] addr_q;
   logic              match;
   logic              take;

   assign match = ((addr_q & ent_mask) ^ ent_net) == '0;
   assign take  = match && ((ent_len > best_len) ||
                            ((ent_len == best_len) && !best_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         best_len <= '0;
         best_hop <= '0;
         best_hit <= 1'b0;
      end else if (load_en) begin
         addr_q   <= load_addr;
         best_len <= load_len;
         best_hop <= load_hop;
         best_hit <= load_hit;
      end else if (ent_en) begin
         if (take) begin
            best_len <= ent_len;
            best_hop <= ent_hop;
         end
         if (match) best_hit <= 1'b1;
      end
   end
endmodule

// File: rtl/lpm_stage.sv
module lpm_stage #(
   parameter int N_LANES = lpm_pkg::DEF_LANES,
   parameter int ADDR_W  = lpm_pkg::DEF_ADDR_W,
   parameter int HOP_W   = lpm_pkg::DEF_HOP_W,
   localparam int LEN_W  = $clog2(ADDR_W + 1),
   localparam int IDX_W  = $clog2(N_LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LEN_W-1:0]  ld_len,
   input  logic [HOP_W-1:0]  ld_hop,
   input  logic              ld_hit,
   input  logic              ent_valid,
   output logic              ent_ready,
   input  logic [ADDR_W-1:0] ent_net,
   input  logic [ADDR_W-1:0] ent_mask,
   input  logic [HOP_W-1:0]  ent_hop,
   input  logic              ent_last,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [LEN_W-1:0]  res_len,
   output logic [HOP_W-1:0]  res_hop,
   output logic              res_hit
);
   import lpm_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_LANES - 1);

   if (N_LANES < 2) begin : g_bad_lanes
      $error("lpm_stage: N_LANES must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("lpm_stage: ADDR_W must be at least 2");
   end
   if (HOP_W < 1) begin : g_bad_hop
      $error("lpm_stage: HOP_W must be at least 1");
   end

   stage_st_t        st;
   logic [IDX_W-1:0] idx;
   logic             ld_fire, ent_fire, res_fire;
   logic [LEN_W-1:0] ent_len;

   logic [LEN_W-1:0] lane_len [N_LANES];
   logic [HOP_W-1:0] lane_hop [N_LANES];
   logic             lane_hit [N_LANES];

   assign ld_ready  = (st == ST_LOAD);
   assign ent_ready = (st == ST_RUN);
   assign res_valid = (st == ST_OUT);
   assign ld_fire   = ld_valid && ld_ready;
   assign ent_fire  = ent_valid && ent_ready;
   assign res_fire  = res_valid && res_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_LOAD;
         idx <= '0;
      end else begin
         unique case (st)
            ST_LOAD: if (ld_fire) begin
               if (idx == LAST_IDX) begin
                  idx <= '0;
                  st  <= ST_RUN;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_RUN: if (ent_fire && ent_last) st <= ST_OUT;
            ST_OUT: if (res_fire) begin
               if (idx == LAST_IDX) begin
                  idx <= '0;
                  st  <= ST_LOAD;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st <= ST_LOAD;
         endcase
      end
   end

   lpm_mask_len #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) mlen_i (
      .mask (ent_mask),
      .len  (ent_len)
   );

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      lpm_lane #(.ADDR_W(ADDR_W), .HOP_W(HOP_W), .LEN_W(LEN_W)) lane_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_en   (ld_fire && (idx == IDX_W'(g))),
         .load_addr (ld_addr),
         .load_len  (ld_len),
         .load_hop  (ld_hop),
         .load_hit  (ld_hit),
         .ent_en    (ent_fire),
         .ent_net   (ent_net),
         .ent_mask  (ent_mask),
         .ent_len   (ent_len),
         .ent_hop   (ent_hop),
         .best_len  (lane_len[g]),
         .best_hop  (lane_hop[g]),
         .best_hit  (lane_hit[g])
      );
   end

   assign res_len = lane_len[idx];
   assign res_hop = lane_hop[idx];
   assign res_hit = lane_hit[idx];
endmodule

// File: rtl/lpm_stage_chk.sv
module lpm_stage_chk #(
   parameter int ADDR_W = lpm_pkg::DEF_ADDR_W,
   parameter int HOP_W  = lpm_pkg::DEF_HOP_W,
   parameter int LEN_W  = $clog2(ADDR_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_ready,
   input logic              ent_valid,
   input logic              ent_ready,
   input logic              ent_last,
   input logic [ADDR_W-1:0] ent_mask,
   input logic [LEN_W-1:0]  ent_len,
   input logic              res_valid,
   input logic              res_ready,
   input logic [LEN_W-1:0]  res_len,
   input logic [HOP_W-1:0]  res_hop,
   input logic              res_hit
);
   logic [LEN_W-1:0] shift_len;

   always_comb begin
      shift_len = '0;
      for (int s = 0; s < ADDR_W; s++) begin
         if ((ent_mask << s) != '0) shift_len = LEN_W'(s + 1);
      end
      if (rst_n) begin
         assert_mask_len_R4: assert (ent_len == shift_len);
      end
   end

   assert_out_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid && ent_ready && ent_last) |=> res_valid);

   assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=>
         (res_valid && $stable(res_len) && $stable(res_hop) && $stable(res_hit)));

   assert_no_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_ready && !(ent_valid && ent_last)) |=> ent_ready);

   assert_no_load_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || ent_ready) |-> !ld_ready);
endmodule

bind lpm_stage lpm_stage_chk #(.ADDR_W(ADDR_W), .HOP_W(HOP_W), .LEN_W(LEN_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_ready  (ld_ready),
   .ent_valid (ent_valid),
   .ent_ready (ent_ready),
   .ent_last  (ent_last),
   .ent_mask  (ent_mask),
   .ent_len   (ent_len),
   .res_valid (res_valid),
   .res_ready (res_ready),
   .res_len   (res_len),
   .res_hop   (res_hop),
   .res_hit   (res_hit)
);

// File: tb/lpm_stage_tb.sv
module lpm_stage_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0, ld_hit = 1'b0;
   logic [31:0] ld_addr = '0;
   logic [5:0]  ld_len = '0;
   logic [15:0] ld_hop = '0;
   logic        ent_valid = 1'b0, ent_last = 1'b0;
   logic [31:0] ent_net = '0, ent_mask = '0;
   logic [15:0] ent_hop = '0;
   logic        res_ready = 1'b0;
   logic        ld_ready, ent_ready, res_valid, res_hit;
   logic [5:0]  res_len;
   logic [15:0] res_hop;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   lpm_stage dut_i (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
      .ld_len(ld_len), .ld_hop(ld_hop), .ld_hit(ld_hit),
      .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_net(ent_net),
      .ent_mask(ent_mask), .ent_hop(ent_hop), .ent_last(ent_last),
      .res_valid(res_valid), .res_ready(res_ready), .res_len(res_len),
      .res_hop(res_hop), .res_hit(res_hit)
   );

   // Scenario data
   logic [31:0] l_addr [8];
   logic [5:0]  l_len  [8];
   logic [15:0] l_hop  [8];
   logic        l_hit  [8];
   logic [31:0] e_net  [8];
   logic [31:0] e_mask [8];
   logic [15:0] e_hop  [8];
   int          n_ent;

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
      end
   endtask

   function automatic logic [5:0] shift_len(input logic [31:0] m);
      logic [31:0] v = m;
      logic [5:0]  k = 0;
      while (v != 0) begin
         v = v << 1;
         k++;
      end
      return k;
   endfunction

   task automatic run_batch(input string tag, input bit bp);
      logic [5:0]  x_len [8];
      logic [15:0] x_hop [8];
      logic        x_hit [8];
      int          bubbles = 0;
      logic [5:0]  h_len;
      logic [15:0] h_hop;
      logic        h_hit;
      // Expected state from the requirements (R3..R7)
      for (int i = 0; i < 8; i++) begin
         x_len[i] = l_len[i]; x_hop[i] = l_hop[i]; x_hit[i] = l_hit[i];
         for (int j = 0; j < n_ent; j++) begin
            logic [5:0] el = shift_len(e_mask[j]);
            if (((l_addr[i] & e_mask[j]) ^ e_net[j]) == 0) begin
               if (el > x_len[i] || (el == x_len[i] && !x_hit[i])) begin
                  x_len[i] = el; x_hop[i] = e_hop[j];
               end
               x_hit[i] = 1'b1;
            end
         end
      end
      // Load phase
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         check(ld_ready === 1'b1, {tag, " R2 ld_ready during load"}, ld_ready, 1);
         ld_valid = 1'b1; ld_addr = l_addr[i]; ld_len = l_len[i];
         ld_hop = l_hop[i]; ld_hit = l_hit[i];
         @(posedge clk);
         @(negedge clk);
      end
      ld_valid = 1'b0;
      check(ld_ready === 1'b0 && ent_ready === 1'b1, {tag, " R2 ready after 8 loads"},
            {ld_ready, ent_ready}, 2'b01);
      // Entry phase, one per cycle
      for (int j = 0; j < n_ent; j++) begin
         if (ent_ready !== 1'b1) bubbles++;
         ent_valid = 1'b1; ent_net = e_net[j]; ent_mask = e_mask[j];
         ent_hop = e_hop[j]; ent_last = (j == n_ent - 1);
         @(posedge clk);
         @(negedge clk);
      end
      ent_valid = 1'b0; ent_last = 1'b0;
      check(bubbles == 0, {tag, " R8 entry port stalled"}, bubbles, 0);
      check(res_valid === 1'b1 && ent_ready === 1'b0, {tag, " R9 results after last"},
            {res_valid, ent_ready}, 2'b10);
      check(ld_ready === 1'b0, {tag, " R10 no load while results pending"}, ld_ready, 0);
      // Output phase
      for (int i = 0; i < 8; i++) begin
         if (bp && i == 3) begin
            res_ready = 1'b0;
            h_len = res_len; h_hop = res_hop; h_hit = res_hit;
            @(posedge clk);
            @(negedge clk);
            check(res_valid === 1'b1 && res_len === h_len && res_hop === h_hop && res_hit === h_hit,
                  {tag, " R9 beat held under backpressure"}, {res_valid, res_len, res_hop},
                  {1'b1, h_len, h_hop});
         end
         res_ready = 1'b1;
         check(res_valid === 1'b1 && res_len === x_len[i],
               $sformatf("%s R3/R4/R5/R6/R7 lane %0d length", tag, i), res_len, x_len[i]);
         check(res_hop === x_hop[i],
               $sformatf("%s R3/R5/R6/R7 lane %0d hop (R9 order)", tag, i), res_hop, x_hop[i]);
         check(res_hit === x_hit[i],
               $sformatf("%s R6 lane %0d flag", tag, i), res_hit, x_hit[i]);
         @(posedge clk);
         @(negedge clk);
      end
      res_ready = 1'b0;
      check(ld_ready === 1'b1 && res_valid === 1'b0, {tag, " R10 back to load"},
            {ld_ready, res_valid}, 2'b10);
   endtask

   task automatic t_reset();
      check(ld_ready === 1'b1 && ent_ready === 1'b0 && res_valid === 1'b0,
            "R1 reset state", {ld_ready, ent_ready, res_valid}, 3'b100);
   endtask

   task automatic t_first_stage();
      l_addr = '{32'h0A010203, 32'h0A01FF00, 32'hC0A80105, 32'h08080808,
                 32'h0A020000, 32'hC0A80200, 32'h0A010280, 32'hAC100001};
      for (int i = 0; i < 8; i++) begin
         l_len[i] = 0; l_hop[i] = 0; l_hit[i] = 0;
      end
      e_net  = '{32'h0A010200, 32'h0A000000, 32'h00000000, 32'h0A010000,
                 32'hC0A80100, 32'h0A010280, 32'h00000000, 32'hAC100000};
      e_mask = '{32'hFFFFFF00, 32'hFF000000, 32'h00000000, 32'hFFFF0000,
                 32'hFFFFFF00, 32'hFFFFFFFF, 32'h00010000, 32'hFFF00000};
      e_hop  = '{16'h0024, 16'h0008, 16'h00DF, 16'h0016,
                 16'h0124, 16'h0032, 16'h0777, 16'h0012};
      n_ent = 8;
      run_batch("first", 1'b0);
   endtask

   task automatic t_chained();
      l_addr = '{32'h0A010203, 32'h0A01FF00, 32'hC0A80105, 32'h08080808,
                 32'h0A020000, 32'hC0A80200, 32'h0A010280, 32'hAC100001};
      l_len  = '{6'd24, 6'd16, 6'd24, 6'd0, 6'd8, 6'd0, 6'd32, 6'd16};
      l_hop  = '{16'h0024, 16'h0016, 16'h0124, 16'h00DF,
                 16'h0008, 16'h0000, 16'h0032, 16'h0777};
      l_hit  = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
      e_net  = '{32'h0A010200, 32'h00000000, 32'h0A010200, 32'hAC000000,
                 32'h0A01FF00, 32'h0A000000, 32'h0,         32'h0};
      e_mask = '{32'hFFFFFF00, 32'h00000000, 32'hFFFFFFF0, 32'hFF000000,
                 32'hFFFFFFFF, 32'hFE000000, 32'h0,         32'h0};
      e_hop  = '{16'h0A24, 16'h0BDF, 16'h0A28, 16'h0A08,
                 16'h0A32, 16'h0A07, 16'h0,     16'h0};
      n_ent = 6;
      run_batch("chained", 1'b1);
   endtask

   task automatic t_no_match();
      l_addr = '{32'h01020304, 32'h05060708, 32'h090A0B0C, 32'h0D0E0F10,
                 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 32'h7FFFFFFF};
      l_len  = '{6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd0};
      l_hop  = '{16'h1111, 16'h2222, 16'h3333, 16'h4444,
                 16'h5555, 16'h6666, 16'h7777, 16'h8888};
      l_hit  = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      e_net[0] = 32'h12345678; e_mask[0] = 32'hFFFFFFFF; e_hop[0] = 16'hBEEF;
      n_ent = 1;
      run_batch("nomatch", 1'b1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_stage();
      t_chained();
      t_no_match();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule